// File: doc/BRIEF.md
# Configuration Frame Address Sequencer

This block steps through every configuration frame address of a tiled programmable-logic array, one address per advance strobe, in the fixed order in which the frames are laid out. Each address has three parts: a frame type, a major number that picks a column inside that type, and a minor number that picks a frame inside that column. With each address the block also reports which kind of column is being addressed and how many bits every frame carries. A loader or readback engine uses it as its address source. It pulses `start`, consumes the presented address, strobes `advance` for the next one, and stops once `done` is set.

The array geometry is fixed at elaboration through parameters:

- the number of logic/DSP columns;
- the number of block-memory columns;
- the frame count of the clock-spine column (2, 3 or 4);
- the number of interconnect rows.

Frame type 0 covers these columns in order: the clock-spine column, the left IOB column, the left IOI column, the logic columns from left to right, the right IOI column and the right IOB column. Type 1 holds the block-memory data frames. Type 2 holds the block-memory routing frames. Majors restart at zero in every type.

Top module: `frame_addr_seq`

## Requirements
- R1: While `rst` is high, and after it, until the first `start`, `valid` and `done` are 0 and `ftype`, `major` and `minor` are 0.
- R2: One cycle after `start` is sampled high, the outputs show `valid`=1, `done`=0, address (0,0,0) and `col_kind`=0.
- R3: Each accepted `advance` increments `minor` by one while it is below the column's frame count minus one. Otherwise it sets `minor` to 0 and moves to the next column. The frame counts are: clock column `CLK_FRAMES`, IOB column 2, IOI and logic columns 19, memory data 76, memory routing 19.
- R4: In type 0, `major` 0 is the clock column (`col_kind` 0). `major` 1 is the left IOB column (kind 1). `major` 2 is the left IOI column (kind 2). Majors 3 to `N_LOGIC`+2 are logic columns (kind 3). `major` `N_LOGIC`+3 is the right IOI column (kind 2). `major` `N_LOGIC`+4 is the right IOB column (kind 1).
- R5: After the last type-0 frame, the sequence moves to type 1, majors 0 to `N_MEM`-1 (kind 4). It then moves to type 2, majors 0 to `N_MEM`-1 (kind 5). `major` restarts at 0 at each type change, and `ftype` never decreases except on `start`.
- R6: When `N_MEM` is 0, types 1 and 2 never appear, and the last frame is type 0, major `N_LOGIC`+4, minor 1.
- R7: Between accepted advances, and with `start` low, every output holds its value.
- R8: `done` rises in the same cycle that the last address appears. While `done` is set, `advance` has no effect on any output. `done` stays set until `start`.
- R9: `start` restarts the sequence at (0,0,0) from any point and takes priority over a simultaneous `advance`.
- R10: `frame_bits` always equals 32 + 64 × `N_ROWS`.
- R11: The clock-spine column has exactly `CLK_FRAMES` frames for each of the supported values 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or restart the walk at the first frame |
| advance | input | 1 | Step to the next frame address |
| valid | output | 1 | An address is being presented |
| done | output | 1 | The presented address is the last one |
| ftype | output | 2 | Frame type (0 main, 1 memory data, 2 memory routing) |
| major | output | MW | Column index within the frame type |
| minor | output | 7 | Frame index within the column |
| col_kind | output | 3 | Column kind: 0 clock, 1 IOB, 2 IOI, 3 logic, 4 memory data, 5 memory routing |
| frame_bits | output | FBW | Bits per frame |

## Verification
The bench walks three small geometries end to end: three clock-column sizes, one of them with no memory columns. It compares every frame against an address computed by counting frames through the column list. It checks the boundaries where a column's last minor rolls over:

- A wrong frame count shifts every later address.
- An off-by-one in the right-edge major decode mislabels the IOI and IOB columns.
- A missed type change leaves `major` unreset or lets types 1 and 2 appear when no memory exists.

After the end of the walk the bench keeps strobing `advance`. This catches a `done` that fires one frame early or late, or an address that wraps or keeps moving after the end. Idle gaps and restarts in mid-walk catch outputs that drift without a strobe, and a `start` that loses to `advance`.

// File: rtl/fas_pkg.sv
package fas_pkg;

  typedef enum logic [2:0] {
    CK_CLOCK    = 3'd0,
    CK_IOB      = 3'd1,
    CK_IOI      = 3'd2,
    CK_LOGIC    = 3'd3,
    CK_MEMDATA  = 3'd4,
    CK_MEMROUTE = 3'd5
  } col_kind_e;

  localparam int MINOR_W    = 7;
  localparam int FR_IOB     = 2;
  localparam int FR_WIDE    = 19;
  localparam int FR_MEMDATA = 76;

endpackage

// File: rtl/fas_col_decode.sv
// Maps (frame type, major) to the column kind, its frame count, and
// whether it is the last column of its type.
module fas_col_decode #(
  parameter int N_LOGIC    = 3,
  parameter int N_MEM      = 2,
  parameter int CLK_FRAMES = 3,
  parameter int MW         = 4
) (
  input  logic [1:0]                  ftype,
  input  logic [MW-1:0]               major,
  output fas_pkg::col_kind_e          kind,
  output logic [fas_pkg::MINOR_W-1:0] nframes,
  output logic                        last_major
);
  import fas_pkg::*;

  localparam int LAST_MAIN = N_LOGIC + 4;
  localparam int LAST_MEM  = (N_MEM > 0) ? N_MEM - 1 : 0;

  always_comb begin
    kind       = CK_CLOCK;
    nframes    = MINOR_W'(CLK_FRAMES);
    last_major = 1'b0;
    unique case (ftype)
      2'd0: begin
        last_major = (major == MW'(LAST_MAIN));
        if (major == MW'(0)) begin
          kind    = CK_CLOCK;
          nframes = MINOR_W'(CLK_FRAMES);
        end else if (major == MW'(1) || major == MW'(LAST_MAIN)) begin
          kind    = CK_IOB;
          nframes = MINOR_W'(FR_IOB);
        end else if (major == MW'(2) || major == MW'(N_LOGIC + 3)) begin
          kind    = CK_IOI;
          nframes = MINOR_W'(FR_WIDE);
        end else begin
          kind    = CK_LOGIC;
          nframes = MINOR_W'(FR_WIDE);
        end
      end
      2'd1: begin
        kind       = CK_MEMDATA;
        nframes    = MINOR_W'(FR_MEMDATA);
        last_major = (major == MW'(LAST_MEM));
      end
      default: begin
        kind       = CK_MEMROUTE;
        nframes    = MINOR_W'(FR_WIDE);
        last_major = (major == MW'(LAST_MEM));
      end
    endcase
  end

endmodule

// File: rtl/fas_step.sv
// Next-address logic: minor, then major, then frame type.
module fas_step #(
  parameter int MW      = 4,
  parameter bit HAS_MEM = 1'b1
) (
  input  logic [1:0]                  cur_type,
  input  logic [MW-1:0]               cur_major,
  input  logic [fas_pkg::MINOR_W-1:0] cur_minor,
  input  logic [fas_pkg::MINOR_W-1:0] cur_nframes,
  input  logic                        cur_last_major,
  output logic [1:0]                  nxt_type,
  output logic [MW-1:0]               nxt_major,
  output logic [fas_pkg::MINOR_W-1:0] nxt_minor
);
  import fas_pkg::*;

  logic col_end;
  assign col_end = (cur_minor == cur_nframes - MINOR_W'(1));

  always_comb begin
    nxt_type  = cur_type;
    nxt_major = cur_major;
    nxt_minor = cur_minor + MINOR_W'(1);
    if (col_end) begin
      nxt_minor = '0;
      if (!cur_last_major) begin
        nxt_major = cur_major + MW'(1);
      end else begin
        nxt_major = '0;
        if (HAS_MEM && cur_type != 2'd2) nxt_type = cur_type + 2'd1;
      end
    end
  end

endmodule

// File: rtl/frame_addr_seq.sv
module frame_addr_seq #(
  parameter int N_LOGIC    = 3,
  parameter int N_MEM      = 2,
  parameter int CLK_FRAMES = 3,
  parameter int N_ROWS     = 4,
  localparam int MAXCNT    = (N_LOGIC + 5 > N_MEM) ? N_LOGIC + 5 : N_MEM,
  localparam int MW        = $clog2(MAXCNT + 1),
  localparam int FBITS     = 32 + 64 * N_ROWS,
  localparam int FBW       = $clog2(FBITS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           advance,
  output logic           valid,
  output logic           done,
  output logic [1:0]     ftype,
  output logic [MW-1:0]  major,
  output logic [6:0]     minor,
  output logic [2:0]     col_kind,
  output logic [FBW-1:0] frame_bits
);
  import fas_pkg::*;

  localparam bit         HAS_MEM   = (N_MEM > 0);
  localparam logic [1:0] LAST_TYPE = HAS_MEM ? 2'd2 : 2'd0;

  logic [1:0]         type_q;
  logic [MW-1:0]      major_q;
  logic [MINOR_W-1:0] minor_q;
  logic               valid_q, done_q;
  col_kind_e          kind_q;

  col_kind_e          cur_kind, nxt_kind;
  logic [MINOR_W-1:0] cur_nfr, nxt_nfr;
  logic               cur_last, nxt_last;
  logic [1:0]         nxt_type;
  logic [MW-1:0]      nxt_major;
  logic [MINOR_W-1:0] nxt_minor;
  logic               nxt_is_final;

  fas_col_decode #(.N_LOGIC(N_LOGIC), .N_MEM(N_MEM), .CLK_FRAMES(CLK_FRAMES), .MW(MW))
    u_dec_cur (.ftype(type_q), .major(major_q), .kind(cur_kind),
               .nframes(cur_nfr), .last_major(cur_last));

  fas_step #(.MW(MW), .HAS_MEM(HAS_MEM))
    u_step (.cur_type(type_q), .cur_major(major_q), .cur_minor(minor_q),
            .cur_nframes(cur_nfr), .cur_last_major(cur_last),
            .nxt_type(nxt_type), .nxt_major(nxt_major), .nxt_minor(nxt_minor));

  fas_col_decode #(.N_LOGIC(N_LOGIC), .N_MEM(N_MEM), .CLK_FRAMES(CLK_FRAMES), .MW(MW))
    u_dec_nxt (.ftype(nxt_type), .major(nxt_major), .kind(nxt_kind),
               .nframes(nxt_nfr), .last_major(nxt_last));

  assign nxt_is_final = (nxt_type == LAST_TYPE) && nxt_last &&
                        (nxt_minor == nxt_nfr - MINOR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q  <= '0;
      major_q <= '0;
      minor_q <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      kind_q  <= CK_CLOCK;
    end else if (start) begin
      type_q  <= '0;
      major_q <= '0;
      minor_q <= '0;
      valid_q <= 1'b1;
      done_q  <= 1'b0;
      kind_q  <= CK_CLOCK;
    end else if (advance && valid_q && !done_q) begin
      type_q  <= nxt_type;
      major_q <= nxt_major;
      minor_q <= nxt_minor;
      kind_q  <= nxt_kind;
      done_q  <= nxt_is_final;
    end
  end

  assign valid      = valid_q;
  assign done       = done_q;
  assign ftype      = type_q;
  assign major      = major_q;
  assign minor      = minor_q;
  assign col_kind   = kind_q;
  assign frame_bits = FBW'(FBITS);

  // R2: start lands on the first frame
  a_r2_start_origin: assert property (@(posedge clk) disable iff (rst)
    start |=> (valid_q && !done_q && type_q == 2'd0 && major_q == '0 && minor_q == '0));

  // R3: minor stays inside the addressed column
  a_r3_minor_in_range: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (minor_q < cur_nfr));

  // R3: an accepted step either increments minor or rolls it to zero
  a_r3_minor_step: assert property (@(posedge clk) disable iff (rst)
    (valid_q && advance && !done_q && !start) |=>
      (minor_q == $past(minor_q) + MINOR_W'(1)) || (minor_q == '0));

  // R5: frame type never goes backwards without start
  a_r5_type_order: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !start) |=> (type_q >= $past(type_q)));

  // R4/R5: registered kind agrees with the decoded column
  a_r4_kind_matches: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (kind_q == cur_kind));

  // R7: nothing moves without a strobe
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!advance && !start) |=> ($stable(type_q) && $stable(major_q) && $stable(minor_q) && $stable(done_q)));

  // R8: done is sticky and freezes the address
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> (done_q && $stable(major_q) && $stable(minor_q) && $stable(type_q)));

  generate
    if (!HAS_MEM) begin : g_nomem_chk
      // R6: without memory columns only type 0 is ever presented
      a_r6_main_only: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (type_q == 2'd0));
    end
  endgenerate

endmodule

// File: tb/tb_frame_addr_seq.sv
module tb_frame_addr_seq;

  localparam int A_NL = 3, A_NM = 2, A_CK = 3, A_ROWS = 4;
  localparam int B_NL = 2, B_NM = 0, B_CK = 4, B_ROWS = 2;
  localparam int C_NL = 1, C_NM = 1, C_CK = 2, C_ROWS = 1;

  localparam int A_MW  = $clog2(((A_NL + 5 > A_NM) ? A_NL + 5 : A_NM) + 1);
  localparam int B_MW  = $clog2(((B_NL + 5 > B_NM) ? B_NL + 5 : B_NM) + 1);
  localparam int C_MW  = $clog2(((C_NL + 5 > C_NM) ? C_NL + 5 : C_NM) + 1);
  localparam int A_FBW = $clog2(32 + 64 * A_ROWS + 1);
  localparam int B_FBW = $clog2(32 + 64 * B_ROWS + 1);
  localparam int C_FBW = $clog2(32 + 64 * C_ROWS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic advance = 1'b0;

  always #2 clk = ~clk;

  logic a_v, a_d, b_v, b_d, c_v, c_d;
  logic [1:0] a_t, b_t, c_t;
  logic [A_MW-1:0] a_mj;
  logic [B_MW-1:0] b_mj;
  logic [C_MW-1:0] c_mj;
  logic [6:0] a_mn, b_mn, c_mn;
  logic [2:0] a_k, b_k, c_k;
  logic [A_FBW-1:0] a_fb;
  logic [B_FBW-1:0] b_fb;
  logic [C_FBW-1:0] c_fb;

  frame_addr_seq #(.N_LOGIC(A_NL), .N_MEM(A_NM), .CLK_FRAMES(A_CK), .N_ROWS(A_ROWS)) dut (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .valid(a_v), .done(a_d),
    .ftype(a_t), .major(a_mj), .minor(a_mn), .col_kind(a_k), .frame_bits(a_fb));

  frame_addr_seq #(.N_LOGIC(B_NL), .N_MEM(B_NM), .CLK_FRAMES(B_CK), .N_ROWS(B_ROWS)) dut_b (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .valid(b_v), .done(b_d),
    .ftype(b_t), .major(b_mj), .minor(b_mn), .col_kind(b_k), .frame_bits(b_fb));

  frame_addr_seq #(.N_LOGIC(C_NL), .N_MEM(C_NM), .CLK_FRAMES(C_CK), .N_ROWS(C_ROWS)) dut_c (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .valid(c_v), .done(c_d),
    .ftype(c_t), .major(c_mj), .minor(c_mn), .col_kind(c_k), .frame_bits(c_fb));

  int n_vec = 0;
  int n_bad = 0;

  function automatic int kind_frames(input int kd, input int ck);
    case (kd)
      0: return ck;
      1: return 2;
      4: return 76;
      default: return 19;
    endcase
  endfunction

  function automatic int total_frames(input int nl, input int nm, input int ck);
    return ck + 2 + 19 + 19 * nl + 19 + 2 + 95 * nm;
  endfunction

  // Locate frame number k by walking the column list and subtracting sizes.
  function automatic void exp_at(input int nl, input int nm, input int ck, input int k,
                                 output int t, output int mj, output int mn, output int kd);
    int idx = k;
    t = 0; mj = 0; mn = 0; kd = 0;
    for (int ty = 0; ty < 3; ty++) begin
      int nmaj = (ty == 0) ? nl + 5 : nm;
      for (int j = 0; j < nmaj; j++) begin
        int kk;
        if (ty == 1) kk = 4;
        else if (ty == 2) kk = 5;
        else if (j == 0) kk = 0;
        else if (j == 1 || j == nl + 4) kk = 1;
        else if (j == 2 || j == nl + 3) kk = 2;
        else kk = 3;
        if (idx < kind_frames(kk, ck)) begin
          t = ty; mj = j; mn = idx; kd = kk;
          return;
        end
        idx -= kind_frames(kk, ck);
      end
    end
  endfunction

  task automatic one(input string req, input string who, input string what,
                     input int act, input int expv, inout bit ok);
    if (act != expv) begin
      $display("FAIL %s %s %s: actual %0d expected %0d", req, who, what, act, expv);
      ok = 1'b0;
    end
  endtask

  // One vector: compare the presented frame against frame k (clamped at the end).
  task automatic chk(input string who, input int nl, input int nm, input int ck, input int rows,
                     input int k, input int v, input int d, input int t, input int mj,
                     input int mn, input int kd, input int fb);
    int et, emj, emn, ekd, tot, kk;
    bit ok = 1'b1;
    tot = total_frames(nl, nm, ck);
    kk = (k < tot) ? k : tot - 1;
    exp_at(nl, nm, ck, kk, et, emj, emn, ekd);
    n_vec++;
    one("R2", who, "valid", v, 1, ok);
    one("R8", who, "done", d, (k >= tot - 1) ? 1 : 0, ok);
    one("R5", who, "ftype", t, et, ok);
    one("R4", who, "major", mj, emj, ok);
    one("R3", who, "minor", mn, emn, ok);
    one("R4", who, "kind", kd, ekd, ok);
    one("R10", who, "frame_bits", fb, 32 + 64 * rows, ok);
    if (!ok) n_bad++;
  endtask

  task automatic chk_all(input int k);
    chk("A", A_NL, A_NM, A_CK, A_ROWS, k, a_v, a_d, a_t, a_mj, a_mn, a_k, a_fb);
    chk("B", B_NL, B_NM, B_CK, B_ROWS, k, b_v, b_d, b_t, b_mj, b_mn, b_k, b_fb);
    chk("C", C_NL, C_NM, C_CK, C_ROWS, k, c_v, c_d, c_t, c_mj, c_mn, c_k, c_fb);
  endtask

  task automatic chk_reset();
    bit ok = 1'b1;
    n_vec++;
    one("R1", "A", "valid", a_v, 0, ok); one("R1", "A", "done", a_d, 0, ok);
    one("R1", "A", "addr", a_t + a_mj + a_mn, 0, ok);
    one("R1", "B", "valid", b_v, 0, ok); one("R1", "B", "done", b_d, 0, ok);
    one("R1", "B", "addr", b_t + b_mj + b_mn, 0, ok);
    one("R1", "C", "valid", c_v, 0, ok); one("R1", "C", "done", c_d, 0, ok);
    one("R1", "C", "addr", c_t + c_mj + c_mn, 0, ok);
    if (!ok) n_bad++;
  endtask

  task automatic pulse_start(input bit with_adv);
    @(negedge clk); start = 1'b1; advance = with_adv;
    @(negedge clk); start = 1'b0; advance = 1'b0;
  endtask

  task automatic pulse_adv();
    @(negedge clk); advance = 1'b1;
    @(negedge clk); advance = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog R8: actual hung expected finished");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int max_tot;
    repeat (3) @(negedge clk);
    chk_reset();                 // R1 during reset
    rst = 1'b0;
    pulse_adv();                 // advance before start: no effect (R1)
    chk_reset();

    pulse_start(1'b0);
    chk_all(0);                  // R2, R11 (clock column first)

    // Full walk of all three geometries (R3, R4, R5, R6, R11); extra
    // strobes past the end exercise R8; idle gaps exercise R7.
    max_tot = total_frames(A_NL, A_NM, A_CK);
    for (int k = 1; k < max_tot + 4; k++) begin
      pulse_adv();
      chk_all(k);
      if (k % 17 == 0) begin
        repeat (3) @(negedge clk);
        chk_all(k);              // R7 held with no strobe
      end
    end

    // R9: restart in mid-walk, then start winning over advance
    pulse_start(1'b0);
    for (int i = 0; i < 25; i++) pulse_adv();
    chk_all(25);
    pulse_start(1'b0);
    chk_all(0);
    pulse_adv();
    chk_all(1);
    pulse_start(1'b1);           // R9: start and advance together
    chk_all(0);

    // R8: done clears on start after a complete walk of geometry B
    for (int i = 0; i < total_frames(B_NL, B_NM, B_CK) - 1; i++) pulse_adv();
    chk("B", B_NL, B_NM, B_CK, B_ROWS, total_frames(B_NL, B_NM, B_CK) - 1,
        b_v, b_d, b_t, b_mj, b_mn, b_k, b_fb);
    pulse_start(1'b0);
    chk_all(0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule